// File: doc/BRIEF.md
# Fast Interrupt Vector and Bank Selector

This block sits beside an interrupt arbiter and the CPU's entry sequencer. It holds two cached service-routine addresses. When the arbiter accepts a request whose priority and group match an enabled entry, the CPU can jump straight to the routine. It skips the two-branch walk through the vector table, which saves four cycles on entry.

The same acceptance also picks the register bank for the routine. There is one bank-map word for each of the four top priority levels, 12 to 15. Each word holds a 2-bit bank code for every group level. That code goes back to the core to be written into the bank field of its status word, so the routine starts on its own local bank with no context-switch instruction.

Configuration is written through a plain address/data/write-enable port. Each acceptance gives one registered result in the following cycle.

Top module: `irq_fastpath`

## Requirements
- R1: After reset every configuration word is zero. `res_valid_o`, `vec_hit_o`, `vec_addr_o` and `bank_o` are zero. No acceptance at any level hits until an entry is written.
- R2: Configuration writes are decoded from `cfg_addr_i` as follows.
  - Address 2i is the header of entry i: enable at bit 15, group at bits 14:12, level code at bits 11:10, segment at bits 7:0.
  - Address 2i+1 is the 16-bit offset of entry i.
  - Addresses 4 to 7 are the bank-map words for levels 12 to 15.
- R3: An enabled entry hits when two conditions hold. The accepted level must equal 12 plus its level code, so codes 0 to 3 stand for levels 12 to 15. The accepted group must equal its group field. On a hit, `vec_hit_o` is 1 and `vec_addr_o` is {segment, offset}, a 24-bit value.
- R4: An entry with its enable bit at 0 never hits, even when its level and group match.
- R5: When both entries match, entry 0 supplies the address.
- R6: When no enabled entry matches, `vec_hit_o` is 0 and `vec_addr_o` is zero.
- R7: Accepted levels below 12 never hit, whatever the entries hold.
- R8: For an accepted level L from 12 to 15 and group g, the block reads the bank-map word for L and takes its bits 2g+1:2g. Code 2'b10 (local bank 1) and code 2'b11 (local bank 2) appear unchanged on `bank_o`.
- R9: A selected code of 2'b00 (global bank) or the reserved 2'b01 gives `bank_o` = 2'b00.
- R10: For accepted levels below 12, `bank_o` equals `cur_bank_i` as sampled at acceptance.
- R11: `res_valid_o` is high exactly in the cycle after a cycle with `acc_valid_i` high. While no acceptance occurs, `vec_hit_o`, `vec_addr_o` and `bank_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 3 | Configuration word address |
| cfg_wdata_i | input | 16 | Configuration write data |
| acc_valid_i | input | 1 | Arbiter accepted a request this cycle |
| acc_level_i | input | 4 | Priority level of the accepted request |
| acc_group_i | input | 3 | Group level of the accepted request |
| cur_bank_i | input | 2 | Bank field currently in the status word |
| res_valid_o | output | 1 | Result for the previous cycle's acceptance |
| vec_hit_o | output | 1 | A cached entry supplies the routine address |
| vec_addr_o | output | 24 | Routine address {segment, offset} on a hit, else zero |
| bank_o | output | 2 | Bank code to load into the status word |

## Verification
Every result is registered once. Values that are present on the inputs at the edge where `acc_valid_i` is high appear on the outputs right after that edge, and `res_valid_o` drops one edge later. A configuration write takes effect from the edge that captures it, so the next acceptance already sees it. The bench drives every input on the falling edge and holds an acceptance for exactly one rising edge. It samples all outputs on the following falling edge, which is half a period after the result register loads and before the next one can change. The hold check then changes the request inputs with `acc_valid_i` low and samples again one full period later.

// File: rtl/irq_fp_pkg.sv
package irq_fp_pkg;
  localparam int SEG_W      = 8;
  localparam int OFF_W      = 16;
  localparam int TGT_W      = SEG_W + OFF_W;
  localparam int DATA_W     = 16;
  localparam int PRIO_W     = 4;
  localparam int GRP_W      = 3;
  localparam int BANK_W     = 2;
  localparam int LVL_BASE   = 12;
  localparam int NUM_LVL    = 4;
  localparam int LIDX_W     = $clog2(NUM_LVL);
  localparam int MAP_W      = BANK_W << GRP_W;
  localparam int HDR_EN_BIT = 15;
  localparam int HDR_GRP_LSB = 12;
  localparam int HDR_LVL_LSB = 10;

  typedef struct packed {
    logic               en;
    logic [LIDX_W-1:0]  lvl;
    logic [GRP_W-1:0]   grp;
    logic [SEG_W-1:0]   seg;
    logic [OFF_W-1:0]   off;
  } fast_ent_t;
endpackage

// File: rtl/irq_fp_cfg.sv
module irq_fp_cfg
  import irq_fp_pkg::*;
#(
  parameter int NUM_ENT = 2,
  parameter int ADDR_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output fast_ent_t         ent_o [NUM_ENT],
  output logic [MAP_W-1:0]  map_o [NUM_LVL]
);
  logic unused_rsvd;
  assign unused_rsvd = ^wdata_i[9:8];

  for (genvar i = 0; i < NUM_ENT; i++) begin : g_ent
    localparam logic [ADDR_W-1:0] A_HDR = ADDR_W'(2 * i);
    localparam logic [ADDR_W-1:0] A_OFF = ADDR_W'(2 * i + 1);
    fast_ent_t ent_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ent_q <= '0;
      end else if (we_i && addr_i == A_HDR) begin
        ent_q.en  <= wdata_i[HDR_EN_BIT];
        ent_q.grp <= wdata_i[HDR_GRP_LSB +: GRP_W];
        ent_q.lvl <= wdata_i[HDR_LVL_LSB +: LIDX_W];
        ent_q.seg <= wdata_i[SEG_W-1:0];
      end else if (we_i && addr_i == A_OFF) begin
        ent_q.off <= wdata_i[OFF_W-1:0];
      end
    end
    assign ent_o[i] = ent_q;

    // R2: offset word lands in the addressed entry
    a_r2_off_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && addr_i == A_OFF) |=> ent_o[i].off == $past(wdata_i[OFF_W-1:0]));
  end

  for (genvar k = 0; k < NUM_LVL; k++) begin : g_map
    localparam logic [ADDR_W-1:0] A_MAP = ADDR_W'(2 * NUM_ENT + k);
    logic [MAP_W-1:0] map_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        map_q <= '0;
      else if (we_i && addr_i == A_MAP)   map_q <= wdata_i[MAP_W-1:0];
    end
    assign map_o[k] = map_q;

    a_r2_map_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && addr_i == A_MAP) |=> map_o[k] == $past(wdata_i[MAP_W-1:0]));
  end
endmodule

// File: rtl/irq_fp_match.sv
module irq_fp_match
  import irq_fp_pkg::*;
#(
  parameter int NUM_ENT = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  fast_ent_t         ent_i [NUM_ENT],
  input  logic [PRIO_W-1:0] level_i,
  input  logic [GRP_W-1:0]  group_i,
  output logic              hit_o,
  output logic [TGT_W-1:0]  target_o
);
  logic              in_range;
  logic [PRIO_W-1:0] rel;
  logic [NUM_ENT-1:0] match, grant;
  logic unused_rel;

  assign rel        = level_i - PRIO_W'(LVL_BASE);
  assign in_range   = level_i >= PRIO_W'(LVL_BASE);
  assign unused_rel = ^rel[PRIO_W-1:LIDX_W];

  for (genvar i = 0; i < NUM_ENT; i++) begin : g_cmp
    assign match[i] = in_range && ent_i[i].en &&
                      ent_i[i].lvl == rel[LIDX_W-1:0] &&
                      ent_i[i].grp == group_i;
  end

  // lowest index wins
  always_comb begin
    grant = '0;
    for (int i = NUM_ENT - 1; i >= 0; i--) begin
      if (match[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
      end
    end
  end

  always_comb begin
    target_o = '0;
    for (int i = 0; i < NUM_ENT; i++) begin
      if (grant[i]) target_o = target_o | {ent_i[i].seg, ent_i[i].off};
    end
  end
  assign hit_o = |grant;

  a_r5_one_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant));
  a_r5_low_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match[0] |-> grant[0]);
  a_r4_no_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ent_i[0].en |-> !grant[0]);
endmodule

// File: rtl/irq_fp_bank.sv
module irq_fp_bank
  import irq_fp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MAP_W-1:0]  map_i [NUM_LVL],
  input  logic [PRIO_W-1:0] level_i,
  input  logic [GRP_W-1:0]  group_i,
  input  logic [BANK_W-1:0] cur_bank_i,
  output logic [BANK_W-1:0] bank_o
);
  logic [PRIO_W-1:0] rel;
  logic              in_range;
  logic [MAP_W-1:0]  word;
  logic [BANK_W-1:0] field;
  logic unused_rel;

  assign rel        = level_i - PRIO_W'(LVL_BASE);
  assign in_range   = level_i >= PRIO_W'(LVL_BASE);
  assign unused_rel = ^rel[PRIO_W-1:LIDX_W];
  assign word       = map_i[rel[LIDX_W-1:0]];
  assign field      = BANK_W'(word >> (BANK_W * int'(group_i)));

  // codes with msb clear fold to the global bank
  always_comb begin
    if (!in_range)      bank_o = cur_bank_i;
    else if (field[1])  bank_o = field;
    else                bank_o = '0;
  end

  a_r9_no_reserved: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_range |-> bank_o != 2'b01);
endmodule

// File: rtl/irq_fastpath.sv
module irq_fastpath
  import irq_fp_pkg::*;
#(
  parameter int NUM_ENT = 2,
  parameter int ADDR_W  = $clog2(2 * NUM_ENT + NUM_LVL)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  input  logic              acc_valid_i,
  input  logic [PRIO_W-1:0] acc_level_i,
  input  logic [GRP_W-1:0]  acc_group_i,
  input  logic [BANK_W-1:0] cur_bank_i,
  output logic              res_valid_o,
  output logic              vec_hit_o,
  output logic [TGT_W-1:0]  vec_addr_o,
  output logic [BANK_W-1:0] bank_o
);
  fast_ent_t         ent [NUM_ENT];
  logic [MAP_W-1:0]  map [NUM_LVL];
  logic              hit_d;
  logic [TGT_W-1:0]  tgt_d;
  logic [BANK_W-1:0] bank_d;

  irq_fp_cfg #(.NUM_ENT(NUM_ENT), .ADDR_W(ADDR_W)) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .addr_i (cfg_addr_i),
    .wdata_i(cfg_wdata_i),
    .ent_o  (ent),
    .map_o  (map)
  );

  irq_fp_match #(.NUM_ENT(NUM_ENT)) u_match (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ent_i   (ent),
    .level_i (acc_level_i),
    .group_i (acc_group_i),
    .hit_o   (hit_d),
    .target_o(tgt_d)
  );

  irq_fp_bank u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .map_i     (map),
    .level_i   (acc_level_i),
    .group_i   (acc_group_i),
    .cur_bank_i(cur_bank_i),
    .bank_o    (bank_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0;
      vec_hit_o   <= 1'b0;
      vec_addr_o  <= '0;
      bank_o      <= '0;
    end else begin
      res_valid_o <= acc_valid_i;
      if (acc_valid_i) begin
        vec_hit_o  <= hit_d;
        vec_addr_o <= tgt_d;
        bank_o     <= bank_d;
      end
    end
  end

  a_r11_valid_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i |=> res_valid_o);
  a_r11_valid_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_valid_i |=> !res_valid_o);
  a_r11_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_valid_i |=> ($stable(vec_hit_o) && $stable(vec_addr_o) && $stable(bank_o)));
  a_r6_miss_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && !vec_hit_o) |-> vec_addr_o == '0);
  a_r7_low_no_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && acc_level_i < PRIO_W'(LVL_BASE)) |=> !vec_hit_o);
  a_r10_low_bank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && acc_level_i < PRIO_W'(LVL_BASE)) |=> bank_o == $past(cur_bank_i));
endmodule

// File: tb/irq_fastpath_tb_top.sv
`timescale 1ns/1ps
module irq_fastpath_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [2:0]  cfg_addr_i = '0;
  logic [15:0] cfg_wdata_i = '0;
  logic        acc_valid_i = 1'b0;
  logic [3:0]  acc_level_i = '0;
  logic [2:0]  acc_group_i = '0;
  logic [1:0]  cur_bank_i = '0;
  logic        res_valid_o;
  logic        vec_hit_o;
  logic [23:0] vec_addr_o;
  logic [1:0]  bank_o;

  int n_run = 0;
  int n_fail = 0;
  logic done = 1'b0;

  logic [15:0] m_hdr [2];
  logic [15:0] m_off [2];
  logic [15:0] m_map [4];

  always #4 clk_i = ~clk_i;

  irq_fastpath dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i),
    .cfg_wdata_i(cfg_wdata_i), .acc_valid_i(acc_valid_i), .acc_level_i(acc_level_i),
    .acc_group_i(acc_group_i), .cur_bank_i(cur_bank_i), .res_valid_o(res_valid_o),
    .vec_hit_o(vec_hit_o), .vec_addr_o(vec_addr_o), .bank_o(bank_o)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_addr_i = 3'(a); cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    if (a < 4) begin
      if (a % 2 == 0) m_hdr[a/2] = d; else m_off[a/2] = d;
    end else m_map[a-4] = d;
  endtask

  task automatic accept(input int lvl, input int grp, input int cb);
    @(negedge clk_i);
    acc_valid_i = 1'b1; acc_level_i = 4'(lvl); acc_group_i = 3'(grp); cur_bank_i = 2'(cb);
    @(negedge clk_i);
    acc_valid_i = 1'b0;
  endtask

  function automatic bit ent_match(input int i, input int lvl, input int grp);
    return lvl >= 12 && m_hdr[i][11:10] == 2'(lvl - 12) && m_hdr[i][14:12] == 3'(grp);
  endfunction

  task automatic sweep(input string base_tag);
    for (int lvl = 0; lvl < 16; lvl++) begin
      for (int grp = 0; grp < 8; grp++) begin
        int cb;
        logic eh; logic [23:0] ea; logic [1:0] eb, code;
        string th, tb;
        bit m0, m1, d0, d1;
        cb = (lvl + 3 * grp) % 4;
        m0 = ent_match(0, lvl, grp) && m_hdr[0][15];
        m1 = ent_match(1, lvl, grp) && m_hdr[1][15];
        d0 = ent_match(0, lvl, grp) && !m_hdr[0][15];
        d1 = ent_match(1, lvl, grp) && !m_hdr[1][15];
        eh = m0 | m1;
        ea = m0 ? {m_hdr[0][7:0], m_off[0]} : (m1 ? {m_hdr[1][7:0], m_off[1]} : 24'h0);
        if (lvl < 12) th = "R7";
        else if (m0 && m1) th = "R5";
        else if (d0 || d1) th = "R4";
        else if (eh) th = "R3";
        else th = base_tag;
        if (lvl < 12) begin
          eb = 2'(cb); tb = "R10";
        end else begin
          code = 2'(m_map[lvl-12] >> (2 * grp));
          eb = code[1] ? code : 2'b00;
          tb = code[1] ? "R8" : "R9";
        end
        accept(lvl, grp, cb);
        chk("R11", "res_valid", 32'(res_valid_o), 32'd1);
        chk(th, "vec_hit", 32'(vec_hit_o), 32'(eh));
        chk(th, "vec_addr", 32'(vec_addr_o), 32'(ea));
        chk(tb, "bank", 32'(bank_o), 32'(eb));
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 2; i++) begin m_hdr[i] = '0; m_off[i] = '0; end
    for (int k = 0; k < 4; k++) m_map[k] = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1: reset state
    chk("R1", "res_valid", 32'(res_valid_o), 32'd0);
    chk("R1", "vec_hit", 32'(vec_hit_o), 32'd0);
    chk("R1", "vec_addr", 32'(vec_addr_o), 32'd0);
    chk("R1", "bank", 32'(bank_o), 32'd0);
    sweep("R1");

    // config A: entry0 lvl15 grp0, entry1 lvl12 grp5
    wr(0, 16'h8C12); wr(1, 16'h3456);
    wr(2, 16'hD0AB); wr(3, 16'hCDEF);
    wr(4, 16'h0002); wr(5, 16'hE4E4); wr(6, 16'h0300); wr(7, 16'h1B1B);
    // R2: address decode of entry 1
    accept(12, 5, 0);
    chk("R2", "vec_addr", 32'(vec_addr_o), 32'h00ABCDEF);
    accept(14, 4, 0);
    chk("R2", "bank", 32'(bank_o), 32'd3);
    sweep("R6");

    // config B: both entries lvl15 grp0
    wr(2, 16'h8C34);
    sweep("R6");

    // config C: entry0 disabled, entry1 still matching
    wr(0, 16'h0C12);
    sweep("R6");

    // config D: entry1 offset change, entry1 at lvl13 grp7
    wr(2, 16'hF477); wr(3, 16'h0001);
    sweep("R6");

    // R11: outputs hold without acceptance
    accept(13, 7, 2);
    chk("R11", "vec_hit", 32'(vec_hit_o), 32'd1);
    @(negedge clk_i);
    acc_level_i = 4'd3; acc_group_i = 3'd1; cur_bank_i = 2'd1;
    @(negedge clk_i);
    chk("R11", "res_valid idle", 32'(res_valid_o), 32'd0);
    chk("R11", "vec_hit hold", 32'(vec_hit_o), 32'd1);
    chk("R11", "vec_addr hold", 32'(vec_addr_o), 32'h00770001);
    chk("R11", "bank hold", 32'(bank_o), 32'(2'(m_map[1] >> 14) & 2'b11));

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule